// File: doc/BRIEF.md
# Soft-Start and Hiccup Fault Sequencer

This block is the digital sequencer of a dual-output supply controller: one switching output and one linear output. Both bias-supply power-valid flags must be true before anything starts. The order in which they arrive does not matter. The block then produces a stepped reference code. The code holds at zero for a short initialization phase, then climbs by one step per step-clock cycle to the regulation value and holds there. A single code port drives the reference of both regulators, so both outputs rise together. A shared enable turns both outputs on and off.

The block reads three comparator flags, each through a two-flop synchronizer: an undervoltage flag for each output and an external shutdown flag. An undervoltage condition disables both outputs at once and starts a hiccup retry. The retry runs a number of silent soft-start cycles with the outputs off and the fault status high, followed by one real soft-start. Undervoltage is ignored early in every ramp. A held shutdown flag keeps both outputs off, and its release starts a fresh soft-start. The power-valid flags are taken as synchronous to the step clock. If either one drops, the block returns to its idle state on the next edge.

Top module: `softstart_seq`

## Requirements
- R1: `out_en_o`, `fault_o` and `ref_code_o` are 0 in reset and whenever either power-valid flag is low. The soft-start begins on the first step-clock edge at which both flags are seen high, whichever flag came first.
- R2: After the enable rises, `ref_code_o` stays 0 for INIT_CYC cycles (default 4). It then rises by exactly 1 per step-clock cycle up to FULL_CODE (default 27) and holds that value.
- R3: `ref_code_o` never exceeds FULL_CODE and is 0 whenever `out_en_o` is low.
- R4: Every rise of `out_en_o` starts with `ref_code_o` equal to 0.
- R5: A high level on either undervoltage flag is acted on at the third step-clock edge after it is first sampled, counting the two synchronizer flops. At that edge `out_en_o` falls, `ref_code_o` becomes 0 and `fault_o` rises.
- R6: `fault_o` then stays high, with the outputs off, for DUMMY_RAMPS*(INIT_CYC+FULL_CODE) cycles (default 93). After that a real soft-start follows with `fault_o` low.
- R7: Undervoltage is ignored while the ramp code that the sequencer holds is below UV_UNMASK (default 10). If undervoltage persists, each real retry keeps the enable high for exactly INIT_CYC+UV_UNMASK cycles (default 14) and then faults again, without end.
- R8: A high shutdown flag turns the outputs off and clears `fault_o` at the third edge. While shutdown is held, undervoltage has no effect. After release, a fresh soft-start begins at the third edge.
- R9: A drop of either power-valid flag clears `out_en_o`, `ref_code_o` and `fault_o` at the next edge, including during a hiccup retry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Step clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pwr_ok_a_i | input | 1 | First bias supply above its power-on threshold |
| pwr_ok_b_i | input | 1 | Second bias supply above its power-on threshold |
| uv_a_i | input | 1 | Undervoltage comparator flag, switching output |
| uv_b_i | input | 1 | Undervoltage comparator flag, linear output |
| shdn_i | input | 1 | External shutdown comparator flag |
| ref_code_o | output | CODE_W | Shared reference DAC code |
| out_en_o | output | 1 | Shared enable for both outputs |
| fault_o | output | 1 | High during the silent hiccup cycles |

## Verification
The sharpest collision is an undervoltage sample that lands on the very edge where the ramp code crosses the unmask threshold. A random pulse position across the whole ramp is compared against a bench prediction of the code the sequencer held when the synchronized flag reached it. A second collision is shutdown or power loss during a hiccup retry. The bench forces these mid-retry and checks that the fault is cleared and that release starts a clean ramp from zero. A persistent undervoltage is also held across several retries, and the enable window and peak code of each retry are measured.

// File: rtl/ss_pkg.sv
package ss_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INIT,
    ST_RAMP,
    ST_RUN,
    ST_SHDN
  } ss_state_e;
endpackage

// File: rtl/ss_sync.sv
module ss_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= d_i[i];
        s2_q <= s1_q;
      end
    end
    assign q_o[i] = s2_q;
  end
endmodule

// File: rtl/ss_ramp.sv
module ss_ramp #(
  parameter int CODE_W    = 5,
  parameter int FULL_CODE = 27
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              step_i,
  output logic [CODE_W-1:0] code_o,
  output logic              full_o
);
  localparam logic [CODE_W-1:0] FULL_C = CODE_W'(FULL_CODE);

  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        code_q <= '0;
    else if (clr_i)                     code_q <= '0;
    else if (step_i && code_q != FULL_C) code_q <= code_q + 1'b1;
  end

  assign code_o = code_q;
  assign full_o = (code_q == FULL_C);
endmodule

// File: rtl/ss_ctrl.sv
module ss_ctrl
  import ss_pkg::*;
#(
  parameter int CODE_W      = 5,
  parameter int INIT_CYC    = 4,
  parameter int DUMMY_RAMPS = 3,
  parameter int UV_UNMASK   = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_ok_i,
  input  logic              uv_i,
  input  logic              shdn_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              full_i,
  output logic              ramp_clr_o,
  output logic              ramp_step_o,
  output logic              out_en_o,
  output logic              fault_o
);
  localparam int INIT_W = $clog2(INIT_CYC + 1);
  localparam int DCNT_W = $clog2(DUMMY_RAMPS + 1);
  localparam logic [INIT_W-1:0] INIT_LAST  = INIT_W'(INIT_CYC - 1);
  localparam logic [DCNT_W-1:0] DUMMY_LAST = DCNT_W'(DUMMY_RAMPS - 1);
  localparam logic [CODE_W-1:0] UNMASK_C   = CODE_W'(UV_UNMASK);

  ss_state_e         st_q, st_d;
  logic [INIT_W-1:0] init_q, init_d;
  logic [DCNT_W-1:0] dcnt_q, dcnt_d;
  logic              dummy_q, dummy_d;
  logic              uv_hit;

  // UV counts only in a real cycle, past the mask point
  assign uv_hit = uv_i && !dummy_q &&
                  ((st_q == ST_RAMP && code_i >= UNMASK_C) || st_q == ST_RUN);

  always_comb begin
    st_d        = st_q;
    init_d      = init_q;
    dcnt_d      = dcnt_q;
    dummy_d     = dummy_q;
    ramp_clr_o  = 1'b0;
    ramp_step_o = 1'b0;
    if (!pwr_ok_i) begin
      st_d       = ST_IDLE;
      dummy_d    = 1'b0;
      dcnt_d     = '0;
      ramp_clr_o = 1'b1;
    end else if (shdn_i) begin
      st_d       = ST_SHDN;
      dummy_d    = 1'b0;
      dcnt_d     = '0;
      ramp_clr_o = 1'b1;
    end else if (uv_hit) begin
      st_d       = ST_INIT;
      init_d     = '0;
      dummy_d    = 1'b1;
      dcnt_d     = '0;
      ramp_clr_o = 1'b1;
    end else begin
      unique case (st_q)
        ST_IDLE, ST_SHDN: begin
          st_d       = ST_INIT;
          init_d     = '0;
          dummy_d    = 1'b0;
          ramp_clr_o = 1'b1;
        end
        ST_INIT: begin
          if (init_q == INIT_LAST) begin
            st_d        = ST_RAMP;
            ramp_step_o = 1'b1;
          end else begin
            init_d = init_q + 1'b1;
          end
        end
        ST_RAMP: begin
          if (!full_i) begin
            ramp_step_o = 1'b1;
          end else if (dummy_q) begin
            st_d       = ST_INIT;
            init_d     = '0;
            ramp_clr_o = 1'b1;
            if (dcnt_q == DUMMY_LAST) begin
              dummy_d = 1'b0;
              dcnt_d  = '0;
            end else begin
              dcnt_d = dcnt_q + 1'b1;
            end
          end else begin
            st_d = ST_RUN;
          end
        end
        ST_RUN: st_d = ST_RUN;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      init_q  <= '0;
      dcnt_q  <= '0;
      dummy_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      init_q  <= init_d;
      dcnt_q  <= dcnt_d;
      dummy_q <= dummy_d;
    end
  end

  assign out_en_o = !dummy_q &&
                    (st_q == ST_INIT || st_q == ST_RAMP || st_q == ST_RUN);
  assign fault_o  = dummy_q;
endmodule

// File: rtl/softstart_seq.sv
module softstart_seq #(
  parameter int CODE_W      = 5,
  parameter int FULL_CODE   = 27,
  parameter int INIT_CYC    = 4,
  parameter int DUMMY_RAMPS = 3,
  parameter int UV_UNMASK   = (FULL_CODE * 3) / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_ok_a_i,
  input  logic              pwr_ok_b_i,
  input  logic              uv_a_i,
  input  logic              uv_b_i,
  input  logic              shdn_i,
  output logic [CODE_W-1:0] ref_code_o,
  output logic              out_en_o,
  output logic              fault_o
);
  logic [2:0]        flags_s;
  logic              ramp_clr, ramp_step, ramp_full, en;
  logic [CODE_W-1:0] code;

  ss_sync #(.W(3)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({shdn_i, uv_b_i, uv_a_i}),
    .q_o   (flags_s)
  );

  ss_ramp #(.CODE_W(CODE_W), .FULL_CODE(FULL_CODE)) u_ramp (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (ramp_clr),
    .step_i(ramp_step),
    .code_o(code),
    .full_o(ramp_full)
  );

  ss_ctrl #(
    .CODE_W     (CODE_W),
    .INIT_CYC   (INIT_CYC),
    .DUMMY_RAMPS(DUMMY_RAMPS),
    .UV_UNMASK  (UV_UNMASK)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pwr_ok_i   (pwr_ok_a_i & pwr_ok_b_i),
    .uv_i       (flags_s[0] | flags_s[1]),
    .shdn_i     (flags_s[2]),
    .code_i     (code),
    .full_i     (ramp_full),
    .ramp_clr_o (ramp_clr),
    .ramp_step_o(ramp_step),
    .out_en_o   (en),
    .fault_o    (fault_o)
  );

  assign out_en_o   = en;
  assign ref_code_o = en ? code : '0;
endmodule

// File: rtl/ss_seq_chk.sv
module ss_seq_chk #(
  parameter int CODE_W    = 5,
  parameter int FULL_CODE = 27,
  parameter int UV_UNMASK = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pwr_ok_a_i,
  input logic              pwr_ok_b_i,
  input logic              shdn_i,
  input logic [CODE_W-1:0] ref_code_o,
  input logic              out_en_o,
  input logic              fault_o
);
  AST_CODE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_code_o <= CODE_W'(FULL_CODE)); // R3

  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_en_o && $past(out_en_o)) |->
      (ref_code_o == $past(ref_code_o) || ref_code_o == $past(ref_code_o) + 1'b1)); // R2

  AST_START_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_en_o) |-> ref_code_o == '0); // R4

  AST_PWR_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pwr_ok_a_i && pwr_ok_b_i) |=> (!out_en_o && !fault_o)); // R9

  AST_FAULT_UNMASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_o) |-> ($past(out_en_o) && $past(ref_code_o) >= CODE_W'(UV_UNMASK))); // R7

  AST_SHDN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(shdn_i, 3) |-> (!out_en_o && !fault_o)); // R8
endmodule

bind softstart_seq ss_seq_chk #(
  .CODE_W   (CODE_W),
  .FULL_CODE(FULL_CODE),
  .UV_UNMASK(UV_UNMASK)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pwr_ok_a_i(pwr_ok_a_i),
  .pwr_ok_b_i(pwr_ok_b_i),
  .shdn_i    (shdn_i),
  .ref_code_o(ref_code_o),
  .out_en_o  (out_en_o),
  .fault_o   (fault_o)
);

// File: tb/softstart_seq_tb.sv
`timescale 1ns/1ps
module softstart_seq_tb;
  localparam int CW   = 5;
  localparam int FULL = 27;
  localparam int INIT = 4;
  localparam int DUM  = 3;
  localparam int UNM  = 10;
  localparam int HICCUP = DUM * (INIT + FULL);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic pa = 1'b0, pb = 1'b0, uva = 1'b0, uvb = 1'b0, shdn = 1'b0;
  logic [CW-1:0] code;
  logic en, fault;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  softstart_seq #(
    .CODE_W(CW), .FULL_CODE(FULL), .INIT_CYC(INIT),
    .DUMMY_RAMPS(DUM), .UV_UNMASK(UNM)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .pwr_ok_a_i(pa), .pwr_ok_b_i(pb),
    .uv_a_i(uva), .uv_b_i(uvb), .shdn_i(shdn),
    .ref_code_o(code), .out_en_o(en), .fault_o(fault)
  );

  function automatic int exp_code(int k);
    if (k < INIT) return 0;
    return (k - INIT + 1 > FULL) ? FULL : k - INIT + 1;
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic start_seq();
    pa = 1'b0; pb = 1'b0;
    tick();
    pa = 1'b1; pb = 1'b1;
    tick();
    chk("R4 start en", int'(en), 1);
    chk("R4 start code", int'(code), 0);
  endtask

  task automatic ramp_from(int k0, int k1);
    for (int k = k0; k <= k1; k++) begin
      tick();
      chk("R2 ramp code", int'(code), exp_code(k));
      chk("R2 ramp en", int'(en), 1);
    end
  endtask

  task automatic count_fault(output int n);
    n = 0;
    while (fault && n < 1000) begin
      if (en) chk("R6 silent en", int'(en), 0);
      n++;
      tick();
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n, m, mx, k;
    bit first_a;
    void'($urandom(32'd4242));
    repeat (3) tick();
    chk("R1 reset en", int'(en), 0);
    chk("R1 reset code", int'(code), 0);
    chk("R1 reset fault", int'(fault), 0);
    rst_ni = 1'b1;
    tick();

    // R1: one supply first, random order and delay
    for (int it = 0; it < 4; it++) begin
      pa = 1'b0; pb = 1'b0;
      tick();
      first_a = 1'($urandom_range(0, 1));
      if (first_a) pa = 1'b1; else pb = 1'b1;
      repeat ($urandom_range(1, 6)) begin
        tick();
        chk("R1 single supply en", int'(en), 0);
      end
      pa = 1'b1; pb = 1'b1;
      tick();
      chk("R1 both supplies en", int'(en), 1);
      chk("R1 both supplies code", int'(code), 0);
    end
    ramp_from(1, 40);

    // R7: UV held only in the masked early part of the ramp
    start_seq();
    uva = 1'b1;
    ramp_from(1, 6);
    uva = 1'b0;
    ramp_from(7, 40);
    chk("R7 masked uv fault", int'(fault), 0);

    // R5/R6: single UV pulse while running
    uvb = 1'b1;
    tick();
    uvb = 1'b0;
    tick();
    chk("R5 uv latency en", int'(en), 1);
    tick();
    chk("R5 uv fault", int'(fault), 1);
    chk("R5 uv en", int'(en), 0);
    chk("R5 uv code", int'(code), 0);
    count_fault(n);
    chk("R6 hiccup length", n, HICCUP);
    chk("R6 retry en", int'(en), 1);
    chk("R6 retry code", int'(code), 0);
    ramp_from(1, 34);
    chk("R6 retry fault", int'(fault), 0);

    // R7: persistent UV repeats the hiccup
    uva = 1'b1;
    n = 0;
    while (!fault && n < 10) begin tick(); n++; end
    chk("R7 persist first fault", int'(fault), 1);
    for (int r = 0; r < 2; r++) begin
      count_fault(n);
      chk("R7 persist hiccup length", n, HICCUP);
      m = 0; mx = 0;
      while (en && m < 100) begin
        if (int'(code) > mx) mx = int'(code);
        m++;
        tick();
      end
      chk("R7 persist en window", m, INIT + UNM);
      chk("R7 persist peak code", mx, UNM);
      chk("R7 persist refault", int'(fault), 1);
    end
    uva = 1'b0;

    // R9: power loss during hiccup
    pb = 1'b0;
    tick();
    chk("R9 drop in hiccup fault", int'(fault), 0);
    chk("R9 drop in hiccup en", int'(en), 0);
    pb = 1'b1;
    tick();
    chk("R9 restore en", int'(en), 1);
    ramp_from(1, 33);

    // R9: power loss while running
    pa = 1'b0;
    tick();
    chk("R9 drop en", int'(en), 0);
    chk("R9 drop code", int'(code), 0);
    pa = 1'b1;
    tick();
    chk("R9 restore code", int'(code), 0);
    ramp_from(1, 33);

    // R8: shutdown held, UV ignored meanwhile
    shdn = 1'b1;
    tick(); tick();
    chk("R8 shdn latency en", int'(en), 1);
    tick();
    chk("R8 shdn en", int'(en), 0);
    chk("R8 shdn code", int'(code), 0);
    uva = 1'b1;
    repeat (20) begin
      tick();
      chk("R8 shdn hold en", int'(en), 0);
      chk("R8 shdn uv fault", int'(fault), 0);
    end
    uva = 1'b0;
    repeat (5) tick();
    shdn = 1'b0;
    tick(); tick();
    chk("R8 release latency en", int'(en), 0);
    tick();
    chk("R8 release en", int'(en), 1);
    chk("R8 release code", int'(code), 0);
    ramp_from(1, 33);

    // R8: shutdown during hiccup clears fault
    uvb = 1'b1;
    tick();
    uvb = 1'b0;
    repeat (10) tick();
    chk("R5 fault before shdn", int'(fault), 1);
    shdn = 1'b1;
    repeat (3) tick();
    chk("R8 shdn clears fault", int'(fault), 0);
    shdn = 1'b0;
    repeat (3) tick();
    chk("R8 fresh start en", int'(en), 1);
    chk("R8 fresh start code", int'(code), 0);

    // R7: random UV pulse position against the unmask point
    for (int it = 0; it < 12; it++) begin
      k = $urandom_range(0, 40);
      start_seq();
      for (int j = 1; j <= k; j++) tick();
      uva = 1'b1;
      tick();
      uva = 1'b0;
      tick(); tick();
      chk("R7 random pulse fault", int'(fault), (exp_code(k + 2) >= UNM) ? 1 : 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule